// File: doc/BRIEF.md
# Four-Phase Charge Transfer Gate Clock Sequencer

This block produces the four logic-level gate clocks that push charge packets along a four-phase CCD shift register. An external level-translation stage converts these clocks to the gate voltages the sensor needs. At every step of the pattern two neighbouring gates are high. One step moves that high pair forward by one gate, so exactly one clock rises and one falls. A full pass through the four steps shifts every packet by one pixel.

Software or a readout controller sets a stage length in system clocks and a number of pixel shifts, then pulses `start_i`. The sequencer latches both values and raises `busy_o`. It runs the requested number of four-stage cycles and then parks in the rest pattern. In the same cycle it drops `busy_o` and pulses `done_o` for one clock. All pins are plain control and status levels. The block has no streaming data interface, so there is no back-pressure to handle.

Top module: `ccd4_phase_seq`

## Requirements
- R1: While reset is held and in the cycle after it, `gate_o` equals 4'b0011, `busy_o` is 0 and `done_o` is 0. Bit 0 of `gate_o` is gate A, bit 1 is B, bit 2 is C and bit 3 is D, so this value means A and B high.
- R2: While running, `gate_o` steps through 4'b0011 (A,B), then 4'b0110 (B,C), then 4'b1100 (C,D), then 4'b1001 (D,A), and then back to 4'b0011. Each stage lasts the latched stage length in clocks. The first stage starts on the edge that accepts the start.
- R3: `gate_o` always has exactly two adjacent bits high, with D and A counted as adjacent. At every change exactly one bit rises and exactly one bit falls, on a single clock edge.
- R4: A stage length of 0 is treated as 1 clock.
- R5: A start pulse seen while idle with a nonzero shift count raises `busy_o` on that edge. `busy_o` then stays high for exactly 4 × shifts × stage-length clocks.
- R6: A start pulse while `busy_o` is high is ignored. The run length and the pattern are unchanged, and only one `done_o` pulse follows.
- R7: On the edge that ends the last cycle, `busy_o` falls, `gate_o` returns to 4'b0011 and `done_o` is high for exactly one clock.
- R8: Shift counts up to 2^SHIFT_W − 1 are supported. The default is 2047, which covers a 1000-pixel line.
- R9: A start pulse with a shift count of 0 is ignored. `busy_o` stays low and no `done_o` appears.
- R10: The stage length and shift count are latched at start. Changing `dwell_i` or `shifts_i` during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request pulse |
| dwell_i | input | DWELL_W | Clocks per stage (0 treated as 1) |
| shifts_i | input | SHIFT_W | Pixel shifts per run |
| gate_o | output | 4 | Gate clocks, bit0=A, bit1=B, bit2=C, bit3=D |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-clock pulse at run end |

## Verification
The assertions check, on every cycle, the following properties:
- the two-adjacent-high shape of the gate vector, and the one-rise-one-fall rule at each change;
- that `busy_o` rises only on a start request;
- that `done_o` lasts a single clock;
- that the block is idle in the rest pattern;
- that the remaining-shift counter never underflows.

Only the bench scenarios can show three things. The first is the exact stage order and stage length against the programmed values. The second is the total run length for a given shift count. The third is that ignored starts and mid-run input changes leave the run untouched.

// File: rtl/ccd4_pkg.sv
package ccd4_pkg;
  typedef logic [3:0] gate_vec_t;
  // rest pattern: gates A and B high
  localparam gate_vec_t GATES_REST = 4'b0011;
  // last stage of a pixel cycle: gates D and A high
  localparam gate_vec_t GATES_WRAP = 4'b1001;

  function automatic gate_vec_t gates_step(input gate_vec_t g);
    return {g[2:0], g[3]};
  endfunction
endpackage

// File: rtl/ccd4_dwell_timer.sv
module ccd4_dwell_timer #(
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic               run_i,
  output logic               tick_o
);
  localparam logic [DWELL_W-1:0] ONE = DWELL_W'(1);

  logic [DWELL_W-1:0] len_q, cnt_q, eff_len;

  assign eff_len = (dwell_i == '0) ? ONE : dwell_i;  // R4
  assign tick_o  = run_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= ONE;
      cnt_q <= '0;
    end else if (load_i) begin
      len_q <= eff_len;
      cnt_q <= eff_len - ONE;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= len_q - ONE;
      else             cnt_q <= cnt_q - ONE;
    end
  end

  assert_len_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    len_q != '0);
endmodule

// File: rtl/ccd4_shift_counter.sv
module ccd4_shift_counter #(
  parameter int SHIFT_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [SHIFT_W-1:0] count_i,
  input  logic               dec_i,
  output logic               last_o
);
  logic [SHIFT_W-1:0] rem_q;

  assign last_o = (rem_q == SHIFT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)         rem_q <= '0;
    else if (load_i) rem_q <= count_i;
    else if (dec_i)  rem_q <= rem_q - SHIFT_W'(1);
  end

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> rem_q != '0);
endmodule

// File: rtl/ccd4_gate_reg.sv
module ccd4_gate_reg
  import ccd4_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      adv_i,
  output gate_vec_t gate_o
);
  gate_vec_t gate_q;

  always_ff @(posedge clk) begin
    if (rst)        gate_q <= GATES_REST;
    else if (adv_i) gate_q <= gates_step(gate_q);
  end

  assign gate_o = gate_q;

  assert_pair_adjacent_R3: assert property (@(posedge clk) disable iff (rst)
    gate_q inside {4'b0011, 4'b0110, 4'b1100, 4'b1001});
  assert_one_rise_one_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_q != $past(gate_q)) |->
      ($countones(gate_q & ~$past(gate_q)) == 1 &&
       $countones(~gate_q & $past(gate_q)) == 1));
endmodule

// File: rtl/ccd4_phase_seq.sv
module ccd4_phase_seq
  import ccd4_pkg::*;
#(
  parameter int DWELL_W = 8,
  parameter int SHIFT_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [DWELL_W-1:0] dwell_i,
  input  logic [SHIFT_W-1:0] shifts_i,
  output logic [3:0]         gate_o,
  output logic               busy_o,
  output logic               done_o
);
  logic      busy_q, done_q, accept, tick, last, pixel_end, finish;
  gate_vec_t gates;

  assign accept    = start_i && !busy_q && (shifts_i != '0);  // R5 R6 R9
  assign pixel_end = tick && (gates == GATES_WRAP);
  assign finish    = pixel_end && last;

  ccd4_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(accept), .dwell_i(dwell_i),
    .run_i(busy_q), .tick_o(tick)
  );

  ccd4_shift_counter #(.SHIFT_W(SHIFT_W)) u_count (
    .clk(clk), .rst(rst), .load_i(accept), .count_i(shifts_i),
    .dec_i(pixel_end), .last_o(last)
  );

  ccd4_gate_reg u_gates (
    .clk(clk), .rst(rst), .adv_i(tick), .gate_o(gates)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
    end
  end

  assign gate_o = gates;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));
  assert_idle_rest_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> gates == GATES_REST);
endmodule

// File: tb/sim_ccd4_phase_seq.sv
module sim_ccd4_phase_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int DW = 8;
  localparam int SW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [DW-1:0] dwell_i = '0;
  logic [SW-1:0] shifts_i = '0;
  logic [3:0] gate_o;
  logic busy_o, done_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd4_phase_seq #(.DWELL_W(DW), .SHIFT_W(SW)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .dwell_i(dwell_i),
    .shifts_i(shifts_i), .gate_o(gate_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int k);
    case (k % 4)
      0: return 4'b0011;
      1: return 4'b0110;
      2: return 4'b1100;
      default: return 4'b1001;
    endcase
  endfunction

  // mode 0: plain; 1: extra start at t=2 (R6); 2: change inputs at t=2 (R10)
  task automatic run_check(input string req, input int n, input int d, input int mode);
    int deff = (d == 0) ? 1 : d;
    int total = 4 * n * deff;
    int bad = 0;
    @(negedge clk);
    shifts_i = SW'(n); dwell_i = DW'(d); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < total; t++) begin
      if (busy_o !== 1'b1 || gate_o !== pat(t / deff) || done_o !== 1'b0) begin
        if (bad == 0)
          check(req, $sformatf("t=%0d gate/busy", t), {gate_o, busy_o}, {pat(t / deff), 1'b1});
        bad++;
      end
      if (mode != 0 && t == 2) begin
        start_i = (mode == 1);
        shifts_i = SW'(5); dwell_i = DW'(7);
      end
      if (t == 3) start_i = 1'b0;
      @(negedge clk);
    end
    check(req, "pattern mismatches", bad, 0);
    check(req, "busy low at end", busy_o, 0);
    check(req, "done at end", done_o, 1);
    check(req, "gates rest at end", gate_o, 4'b0011);
    @(negedge clk);
    check(req, "done one cycle", done_o, 0);
    check(req, "still idle", busy_o, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "gates in reset", gate_o, 4'b0011);
    check("R1", "busy in reset", busy_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "gates after reset", gate_o, 4'b0011);
    check("R1", "busy after reset", busy_o, 0);
    check("R1", "done after reset", done_o, 0);
  endtask

  task automatic test_zero_shifts();
    @(negedge clk);
    shifts_i = '0; dwell_i = DW'(2); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R9", "busy stays low", busy_o, 0);
      check("R9", "no done", done_o, 0);
      check("R9", "gates at rest", gate_o, 4'b0011);
      @(negedge clk);
    end
  endtask

  initial begin
    fork
      begin
        test_reset();
        run_check("R2 R5 R7", 2, 3, 0);
        run_check("R2 R3", 3, 1, 0);
        run_check("R4", 2, 0, 0);
        run_check("R6", 2, 2, 1);
        run_check("R10", 2, 2, 2);
        test_zero_shifts();
        run_check("R8", 1000, 1, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule